// File: doc/BRIEF.md
# Pushbutton Soft/Hard Reset Classifier

This block watches an active-low pushbutton level that has already been synchronized to the local clock. It measures how long each press lasts and sorts it into one of two kinds.

A short press is one released before the hold threshold. After the release, the block waits for a settling interval and then drives one narrow active-low soft-reset pulse. A long press reaches the hold threshold while still held. From that cycle on, the block raises a hard-reset request level and keeps it up for as long as the button stays down. The request drops on release, and the downstream reset timing generator then stretches it into a full reset. A long press never produces a soft pulse.

Every duration is a tick-count parameter, so a bench can scale the durations down. A press only has to be sampled low on one clock edge to count, which covers the very shortest valid press.

The state machine has five states:
- Idle (waiting).
- Held (a press is being timed).
- Long (the hard request is active).
- Settle (the wait after a short release).
- Soft (the pulse is being driven).

Its transitions are:
- Idle→Held on a low sample.
- Held→Settle on a high sample before the threshold.
- Held→Long when the threshold count of consecutive low samples is reached.
- Long→Idle on a high sample.
- Settle→Soft after the settle count.
- Soft→Idle after the pulse count.

Top module: `pushbutton_reset_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released with the button up, `soft_rst_n` is 1 and `hard_req` is 0.
- R2: A press (`btn_n` = 0 means pressed) sampled low on fewer than `HOLD_TICKS` consecutive rising edges is short and yields exactly one soft pulse.
- R3: For a short press, `soft_rst_n` goes to 0 exactly `SETTLE_TICKS` cycles after the first edge that samples the button released.
- R4: The soft pulse (`soft_rst_n` = 0 means active) lasts exactly `PULSE_TICKS` cycles and then returns to 1.
- R5: On the edge that takes the `HOLD_TICKS`-th consecutive low sample, `hard_req` (1 means active) rises.
- R6: `hard_req` stays 1 while the button stays low, and drops on the first edge that samples the button released.
- R7: A press that raised `hard_req` produces no soft pulse after release.
- R8: Button activity during the settle wait or during the soft pulse does not move the pulse and does not start a new press. The block returns to idle with both outputs inactive.
- R9: A press sampled low on a single edge is recognized and yields a soft pulse.
- R10: `soft_rst_n` = 0 and `hard_req` = 1 never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Synchronized pushbutton level, 0 = pressed |
| soft_rst_n | output | 1 | Soft-reset pulse, 0 = active |
| hard_req | output | 1 | Hard-reset request level, 1 = active |

## Verification
The in-RTL assertions check these on every cycle:
- The hard request is only ever high after a low button sample.
- The hard request falls only on a release and returns the machine to idle.
- A soft pulse starts only from the end of a full settle count and ends only at the end of a full pulse count.
- The settle count advances whatever the button does.

Only the bench scenarios can show the rest:
- The exact cycle placement of the pulse relative to release.
- The one-sample-shorter versus exact threshold boundary.
- The absence of a soft pulse after a long hold.
- The fact that presses made during the settle wait or the pulse leave no second pulse behind.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HELD   = 3'd1,
        ST_LONG   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_SOFT   = 3'd4
    } pbr_state_e;

    function automatic int unsigned pbr_max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/pbr_tick_timer.sv
module pbr_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pbr_fsm.sv
module pbr_fsm
    import pbr_pkg::*;
#(
    parameter int HOLD_TICKS   = 2000000,
    parameter int SETTLE_TICKS = 20000,
    parameter int PULSE_TICKS  = 100,
    parameter int CW           = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_n,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          soft_rst_n,
    output logic          hard_req
);
    // the entry edge is itself the first low sample, so the hold count ends two short
    localparam logic [CW-1:0] HOLD_END   = CW'(HOLD_TICKS - 2);
    localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_TICKS - 1);
    localparam logic [CW-1:0] PULSE_END  = CW'(PULSE_TICKS - 1);

    pbr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!btn_n) state_d = ST_HELD;
            ST_HELD: begin
                if (btn_n)                  state_d = ST_SETTLE;
                else if (cnt == HOLD_END)   state_d = ST_LONG;
            end
            ST_LONG:   if (btn_n) state_d = ST_IDLE;
            ST_SETTLE: if (cnt == SETTLE_END) state_d = ST_SOFT;
            ST_SOFT:   if (cnt == PULSE_END)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cnt_clr = (state_d != state_q) || (state_q == ST_IDLE) || (state_q == ST_LONG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        soft_rst_n = (state_q != ST_SOFT);
        hard_req   = (state_q == ST_LONG);
    end

    // R5
    hard_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req |-> !$past(btn_n));

    // R6
    hard_drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_req) |-> $past(btn_n));

    // R7
    hard_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_req) |-> (soft_rst_n && state_q == ST_IDLE));

    // R3
    soft_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst_n) |-> ($past(state_q) == ST_SETTLE && $past(cnt) == SETTLE_END));

    // R4
    soft_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_n) |-> ($past(cnt) == PULSE_END && state_q == ST_IDLE));

    // R8
    settle_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) == ST_SETTLE) |-> (cnt == CW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/pushbutton_reset_ctrl.sv
module pushbutton_reset_ctrl
    import pbr_pkg::*;
#(
    parameter int HOLD_TICKS   = 2000000,
    parameter int SETTLE_TICKS = 20000,
    parameter int PULSE_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic soft_rst_n,
    output logic hard_req
);
    localparam int unsigned MAXT = pbr_max3(HOLD_TICKS, SETTLE_TICKS, PULSE_TICKS);
    localparam int CW = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;
    logic          cnt_clr;

    pbr_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    pbr_fsm #(
        .HOLD_TICKS   (HOLD_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .PULSE_TICKS  (PULSE_TICKS),
        .CW           (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_n      (btn_n),
        .cnt        (cnt),
        .cnt_clr    (cnt_clr),
        .soft_rst_n (soft_rst_n),
        .hard_req   (hard_req)
    );
endmodule

// File: tb/test_pushbutton_reset_ctrl.sv
`timescale 1ns/1ps
module test_pushbutton_reset_ctrl;
    localparam int H  = 12;
    localparam int SD = 6;
    localparam int PW = 4;
    localparam int NV = 6;
    localparam int VLEN [NV] = '{1, 3, H-1, H, H+5, 2};
    localparam bit VHARD [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic soft_rst_n, hard_req;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pushbutton_reset_ctrl #(.HOLD_TICKS(H), .SETTLE_TICKS(SD), .PULSE_TICKS(PW)) i_pushbutton_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .soft_rst_n(soft_rst_n), .hard_req(hard_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
        end
    endtask

    // Observe outputs after release; pulse expected in window j = SD+1 .. SD+PW.
    task automatic watch_release(input string req, input bit pulse_exp, input int span);
        for (int j = 1; j <= span; j++) begin
            @(negedge clk);
            chk(req, "soft_rst_n", soft_rst_n, !(pulse_exp && j > SD && j <= SD + PW));
            chk("R10", "hard_req after release", hard_req, 1'b0);
        end
    endtask

    task automatic press(input int len, input bit exp_hard);
        btn_n = 1'b0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            chk((i >= H) ? "R6" : "R5", "hard_req while held", hard_req, exp_hard && (i >= H));
            chk("R10", "soft_rst_n while held", soft_rst_n, 1'b1);
        end
        btn_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at %0t: actual=hung expected=finished", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "soft_rst_n in reset", soft_rst_n, 1'b1);
        chk("R1", "hard_req in reset", hard_req, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "soft_rst_n after reset", soft_rst_n, 1'b1);
        chk("R1", "hard_req after reset", hard_req, 1'b0);

        // Vector table: R2 short presses, R5/R6/R7 long presses, threshold boundary H-1 / H
        for (int v = 0; v < NV; v++) begin
            press(VLEN[v], VHARD[v]);
            watch_release(VHARD[v] ? "R7" : "R3", !VHARD[v], SD + PW + 3);
        end

        // R9: single-sample press gives a pulse
        press(1, 1'b0);
        watch_release("R9", 1'b1, SD + PW + 3);

        // R8: presses during settle and during pulse are ignored
        btn_n = 1'b0;
        @(negedge clk);
        btn_n = 1'b1;
        for (int j = 1; j <= 2 * (SD + PW) + 4; j++) begin
            @(negedge clk);
            chk("R8", "soft_rst_n with noise", soft_rst_n, !(j > SD && j <= SD + PW));
            chk("R8", "hard_req with noise", hard_req, 1'b0);
            if (j == 2) btn_n = 1'b0;
            if (j == 5) btn_n = 1'b1;
            if (j == SD + 2) btn_n = 1'b0;
            if (j == SD + 3) btn_n = 1'b1;
        end

        // R4: pulse width exact, counted directly
        begin
            int lows = 0;
            press(2, 1'b0);
            for (int j = 1; j <= SD + PW + 4; j++) begin
                @(negedge clk);
                if (!soft_rst_n) lows++;
            end
            checks++;
            if (lows != PW) begin
                failures++;
                $display("FAIL R4 pulse width: actual=%0d expected=%0d", lows, PW);
            end
        end

        // R1: reset in the middle of a pulse restores the inactive outputs
        press(2, 1'b0);
        repeat (SD + 2) @(negedge clk);
        chk("R4", "soft_rst_n mid pulse", soft_rst_n, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "soft_rst_n after mid-pulse reset", soft_rst_n, 1'b1);
        rst_n = 1'b1;
        repeat (SD + PW + 2) @(negedge clk);
        chk("R1", "soft_rst_n stays idle", soft_rst_n, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule